// File: doc/BRIEF.md
# Dual-Bus Registered Transceiver with Bypass

This block joins two bidirectional data buses, A and B, and splits them into byte lanes that are controlled on their own. Each lane holds one capture register per direction. A select picks whether a bus is driven with live data from the other bus or with the stored value. An enable decides whether each bus is driven at all. Every bus pin is modelled as three signals: the value arriving from outside, the value the block drives, and an output enable. The block also reports the resolved value an observer sees on each bus. The controls of all lanes can be tied together to work the full bus width as one unit.

The capture strobes are asynchronous. Each one is synchronized onto the system clock and edge-detected there. On a detected rising edge, the register takes the resolved value of its source bus. This happens whatever the select and enable inputs are doing. The enables have opposite polarities: the A-to-B enable is active high and the B-to-A enable is active low. When both directions are enabled in live mode, the two buses would feed each other. In that case a per-lane holding register keeps the last bus value in place of the combinational loop.

Top module: `dual_bus_xcvr`

## Requirements
- R1: Each lane of LANE_W bits (lane n covers bits n*LANE_W and up) has its own strobes, selects and enables. Activity on one lane never changes another lane's registers or buses.
- R2: A rising edge on `cap_ab[n]` loads the lane's A register with the resolved bus A value. A rising edge on `cap_ba[n]` loads the B register from the resolved bus B value. With SYNC_STAGES=2, the register changes on the third clock edge after the strobe rises.
- R3: A strobe that stays high loads only once. A falling strobe loads nothing.
- R4: Capture happens whatever the select and enable values are. This includes capturing the value the block itself drives onto the source bus.
- R5: `en_ab[n]`=1 sets `b_oe` for the lane to all ones and drives `b_bus` = `b_out`. `en_ab[n]`=0 gives `b_oe`=0, `b_out`=0 and `b_bus`=`b_in`. This takes effect in the same cycle.
- R6: `en_ba_n[n]`=0 sets `a_oe` to all ones and drives `a_bus` = `a_out`. `en_ba_n[n]`=1 gives `a_oe`=0, `a_out`=0 and `a_bus`=`a_in`. With `en_ab`=0 and `en_ba_n`=1 the lane is isolated.
- R7: When B is driven, `sel_ab[n]`=0 puts the live bus A value on B and `sel_ab[n]`=1 puts the stored A register on B.
- R8: When A is driven, `sel_ba[n]`=0 puts the live bus B value on A and `sel_ba[n]`=1 puts the stored B register on A.
- R9: While B carries live A data, a B-side capture stores that A data, so both registers end up with it. The mirror case behaves the same way.
- R10: With both directions enabled and both selects at 0, both buses show the value bus A resolved to on the last clock before this mode began. They keep that value while `a_in` and `b_in` change.
- R11: An active-low synchronous reset clears both data registers and the holding register of every lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_in | input | LANE_W*LANES | Value arriving on bus A from outside |
| b_in | input | LANE_W*LANES | Value arriving on bus B from outside |
| cap_ab | input | LANES | Asynchronous capture strobe, bus A into A register |
| cap_ba | input | LANES | Asynchronous capture strobe, bus B into B register |
| sel_ab | input | LANES | Source for bus B: 0 live A, 1 stored A |
| sel_ba | input | LANES | Source for bus A: 0 live B, 1 stored B |
| en_ab | input | LANES | Drive bus B, active high |
| en_ba_n | input | LANES | Drive bus A, active low |
| a_out | output | LANE_W*LANES | Value driven onto bus A (0 when not driven) |
| a_oe | output | LANE_W*LANES | Per-bit drive enable of bus A |
| b_out | output | LANE_W*LANES | Value driven onto bus B (0 when not driven) |
| b_oe | output | LANE_W*LANES | Per-bit drive enable of bus B |
| a_bus | output | LANE_W*LANES | Resolved bus A value |
| b_bus | output | LANE_W*LANES | Resolved bus B value |

## Verification
The bench uses the defaults: two lanes of eight bits and a two-stage synchronizer. This makes the three-clock capture latency exact and observable. At this size every one of the sixteen select and enable combinations can be swept on lane 0, while lane 1 runs a different combination at the same time. Each resolved value is computed by a case formula in the bench. Stored registers are read back through the stored-select path. This exposes self-capture, store-in-both and the hold in mutual-drive mode.

// File: rtl/dbx_pkg.sv
package dbx_pkg;

   // per-lane control bundle
   typedef struct packed {
      logic cap_ab;
      logic cap_ba;
      logic sel_ab;
      logic sel_ba;
      logic en_ab;
      logic en_ba_n;
   } lane_ctrl_t;

   localparam int unsigned DEF_LANE_W = 8;
   localparam int unsigned DEF_LANES  = 2;
   localparam int unsigned DEF_SYNC   = 2;

endpackage

// File: rtl/dbx_edge.sv
module dbx_edge #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe,
   output logic hit
);

   logic prev_q;
   logic level;

   generate
      if (STAGES == 0) begin : g_direct
         assign level = strobe;
      end else begin : g_sync
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               chain_q <= '0;
            end else begin
               chain_q[0] <= strobe;
               for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
            end
         end
         assign level = chain_q[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= level;
   end

   assign hit = level & ~prev_q;

endmodule

// File: rtl/dbx_lane.sv
module dbx_lane
   import dbx_pkg::*;
#(
   parameter int unsigned W      = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  lane_ctrl_t   ctl,
   input  logic [W-1:0] a_in,
   input  logic [W-1:0] b_in,
   output logic [W-1:0] a_out,
   output logic [W-1:0] a_oe,
   output logic [W-1:0] b_out,
   output logic [W-1:0] b_oe,
   output logic [W-1:0] a_res,
   output logic [W-1:0] b_res,
   output logic [W-1:0] reg_a,
   output logic [W-1:0] reg_b,
   output logic         hit_ab,
   output logic         hit_ba
);

   logic [W-1:0] reg_a_q, reg_b_q, hold_q;
   logic [W-1:0] a_fix_val, b_fix_val;
   logic         drv_a, drv_b, mutual, a_fixed, b_fixed;

   dbx_edge #(.STAGES(STAGES)) u_edge_ab (
      .clk(clk), .rst_n(rst_n), .strobe(ctl.cap_ab), .hit(hit_ab)
   );
   dbx_edge #(.STAGES(STAGES)) u_edge_ba (
      .clk(clk), .rst_n(rst_n), .strobe(ctl.cap_ba), .hit(hit_ba)
   );

   assign drv_b  = ctl.en_ab;
   assign drv_a  = ~ctl.en_ba_n;
   assign mutual = drv_a & drv_b & ~ctl.sel_ab & ~ctl.sel_ba;

   // a side that does not depend on bus B, and vice versa
   assign a_fixed   = ~drv_a | ctl.sel_ba;
   assign b_fixed   = ~drv_b | ctl.sel_ab;
   assign a_fix_val = drv_a ? reg_b_q : a_in;
   assign b_fix_val = drv_b ? reg_a_q : b_in;

   always_comb begin
      if (mutual) begin
         a_res = hold_q;
         b_res = hold_q;
      end else begin
         a_res = a_fixed ? a_fix_val : b_fix_val;
         b_res = b_fixed ? b_fix_val : a_fix_val;
      end
   end

   assign a_oe  = {W{drv_a}};
   assign b_oe  = {W{drv_b}};
   assign a_out = drv_a ? a_res : '0;
   assign b_out = drv_b ? b_res : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         reg_a_q <= '0;
         reg_b_q <= '0;
         hold_q  <= '0;
      end else begin
         if (hit_ab)  reg_a_q <= a_res;
         if (hit_ba)  reg_b_q <= b_res;
         if (!mutual) hold_q  <= a_res;
      end
   end

   assign reg_a = reg_a_q;
   assign reg_b = reg_b_q;

endmodule

// File: rtl/dual_bus_xcvr.sv
module dual_bus_xcvr
   import dbx_pkg::*;
#(
   parameter int unsigned LANE_W      = DEF_LANE_W,
   parameter int unsigned LANES       = DEF_LANES,
   parameter int unsigned SYNC_STAGES = DEF_SYNC
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [LANE_W*LANES-1:0] a_in,
   input  logic [LANE_W*LANES-1:0] b_in,
   input  logic [LANES-1:0]        cap_ab,
   input  logic [LANES-1:0]        cap_ba,
   input  logic [LANES-1:0]        sel_ab,
   input  logic [LANES-1:0]        sel_ba,
   input  logic [LANES-1:0]        en_ab,
   input  logic [LANES-1:0]        en_ba_n,
   output logic [LANE_W*LANES-1:0] a_out,
   output logic [LANE_W*LANES-1:0] a_oe,
   output logic [LANE_W*LANES-1:0] b_out,
   output logic [LANE_W*LANES-1:0] b_oe,
   output logic [LANE_W*LANES-1:0] a_bus,
   output logic [LANE_W*LANES-1:0] b_bus
);

   localparam int unsigned DATA_W = LANE_W * LANES;

   generate
      if (LANE_W < 1)      begin : g_bad_w     $error("LANE_W must be at least 1");      end
      if (LANES < 1)       begin : g_bad_lanes $error("LANES must be at least 1");       end
      if (SYNC_STAGES > 4) begin : g_bad_sync  $error("SYNC_STAGES must not exceed 4"); end
   endgenerate

   logic [DATA_W-1:0] stored_a, stored_b;
   logic [LANES-1:0]  hit_ab, hit_ba;

   generate
      for (genvar n = 0; n < LANES; n++) begin : g_lane
         lane_ctrl_t ctl;
         assign ctl = '{cap_ab: cap_ab[n], cap_ba: cap_ba[n], sel_ab: sel_ab[n],
                        sel_ba: sel_ba[n], en_ab: en_ab[n], en_ba_n: en_ba_n[n]};
         dbx_lane #(.W(LANE_W), .STAGES(SYNC_STAGES)) u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .ctl    (ctl),
            .a_in   (a_in [n*LANE_W +: LANE_W]),
            .b_in   (b_in [n*LANE_W +: LANE_W]),
            .a_out  (a_out[n*LANE_W +: LANE_W]),
            .a_oe   (a_oe [n*LANE_W +: LANE_W]),
            .b_out  (b_out[n*LANE_W +: LANE_W]),
            .b_oe   (b_oe [n*LANE_W +: LANE_W]),
            .a_res  (a_bus[n*LANE_W +: LANE_W]),
            .b_res  (b_bus[n*LANE_W +: LANE_W]),
            .reg_a  (stored_a[n*LANE_W +: LANE_W]),
            .reg_b  (stored_b[n*LANE_W +: LANE_W]),
            .hit_ab (hit_ab[n]),
            .hit_ba (hit_ba[n])
         );
      end
   endgenerate

endmodule

// File: rtl/dbx_checker.sv
module dbx_checker #(
   parameter int unsigned LANE_W = 8,
   parameter int unsigned LANES  = 2
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic [LANE_W*LANES-1:0] a_in,
   input logic [LANE_W*LANES-1:0] b_in,
   input logic [LANES-1:0]        sel_ab,
   input logic [LANES-1:0]        sel_ba,
   input logic [LANES-1:0]        en_ab,
   input logic [LANES-1:0]        en_ba_n,
   input logic [LANE_W*LANES-1:0] a_bus,
   input logic [LANE_W*LANES-1:0] b_bus,
   input logic [LANE_W*LANES-1:0] stored_a,
   input logic [LANE_W*LANES-1:0] stored_b,
   input logic [LANES-1:0]        hit_ab,
   input logic [LANES-1:0]        hit_ba
);

   generate
      for (genvar n = 0; n < LANES; n++) begin : g_chk
         localparam int unsigned LO = n * LANE_W;
         logic mut;
         assign mut = en_ab[n] & ~en_ba_n[n] & ~sel_ab[n] & ~sel_ba[n];

         p_cap_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
            hit_ab[n] |=> stored_a[LO +: LANE_W] == $past(a_bus[LO +: LANE_W]));
         p_cap_b_r2: assert property (@(posedge clk) disable iff (!rst_n)
            hit_ba[n] |=> stored_b[LO +: LANE_W] == $past(b_bus[LO +: LANE_W]));
         p_keep_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
            !hit_ab[n] |=> $stable(stored_a[LO +: LANE_W]));
         p_keep_b_r3: assert property (@(posedge clk) disable iff (!rst_n)
            !hit_ba[n] |=> $stable(stored_b[LO +: LANE_W]));
         p_isolate_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (!en_ab[n] && en_ba_n[n]) |->
               (a_bus[LO +: LANE_W] == a_in[LO +: LANE_W] &&
                b_bus[LO +: LANE_W] == b_in[LO +: LANE_W]));
         p_stored_b_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (en_ab[n] && sel_ab[n]) |-> b_bus[LO +: LANE_W] == stored_a[LO +: LANE_W]);
         p_stored_a_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (!en_ba_n[n] && sel_ba[n]) |-> a_bus[LO +: LANE_W] == stored_b[LO +: LANE_W]);
         p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (mut && $past(mut)) |->
               ($stable(a_bus[LO +: LANE_W]) && b_bus[LO +: LANE_W] == a_bus[LO +: LANE_W]));
      end
   endgenerate

endmodule

bind dual_bus_xcvr dbx_checker #(.LANE_W(LANE_W), .LANES(LANES)) u_dbx_checker (
   .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
   .sel_ab(sel_ab), .sel_ba(sel_ba), .en_ab(en_ab), .en_ba_n(en_ba_n),
   .a_bus(a_bus), .b_bus(b_bus), .stored_a(stored_a), .stored_b(stored_b),
   .hit_ab(hit_ab), .hit_ba(hit_ba)
);

// File: tb/dual_bus_xcvr_test.sv
module dual_bus_xcvr_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] a_in = '0, b_in = '0;
   logic [1:0]  cap_ab = '0, cap_ba = '0, sel_ab = '0, sel_ba = '0;
   logic [1:0]  en_ab = '0, en_ba_n = 2'b11;
   logic [15:0] a_out, a_oe, b_out, b_oe, a_bus, b_bus;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   dual_bus_xcvr uut (
      .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
      .cap_ab(cap_ab), .cap_ba(cap_ba), .sel_ab(sel_ab), .sel_ba(sel_ba),
      .en_ab(en_ab), .en_ba_n(en_ba_n),
      .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe),
      .a_bus(a_bus), .b_bus(b_bus)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // bench model of one lane's resolved buses
   function automatic logic [7:0] exp_a(input bit eab, ebn, sab, sba,
                                        input logic [7:0] ain, bin, ra, rb, hold);
      bit da = !ebn, db = eab;
      if (da && db && !sab && !sba) return hold;
      if (!da) return ain;
      if (sba) return rb;
      return db ? ra : bin;
   endfunction

   function automatic logic [7:0] exp_b(input bit eab, ebn, sab, sba,
                                        input logic [7:0] ain, bin, ra, rb, hold);
      bit da = !ebn, db = eab;
      if (da && db && !sab && !sba) return hold;
      if (!db) return bin;
      if (sab) return ra;
      return da ? rb : ain;
   endfunction

   task automatic strobe(input logic [1:0] mab, input logic [1:0] mba);
      cap_ab = mab; cap_ba = mba;
      repeat (4) @(negedge clk);
      cap_ab = '0; cap_ba = '0;
      repeat (4) @(negedge clk);
   endtask

   // read both registers through the stored-select path
   task automatic read_regs(input string req, input logic [15:0] ra, input logic [15:0] rb);
      en_ab = 2'b11; sel_ab = 2'b11; en_ba_n = 2'b00; sel_ba = 2'b11;
      #1;
      chk({req, " stored A"}, 64'(b_bus), 64'(ra));
      chk({req, " stored B"}, 64'(a_bus), 64'(rb));
   endtask

   task automatic check_lanes(input logic [15:0] ra, rb, hold);
      for (int n = 0; n < 2; n++) begin
         bit eab = en_ab[n], ebn = en_ba_n[n], sab = sel_ab[n], sba = sel_ba[n];
         logic [7:0] ea = exp_a(eab, ebn, sab, sba, a_in[n*8 +: 8], b_in[n*8 +: 8],
                                ra[n*8 +: 8], rb[n*8 +: 8], hold[n*8 +: 8]);
         logic [7:0] eb = exp_b(eab, ebn, sab, sba, a_in[n*8 +: 8], b_in[n*8 +: 8],
                                ra[n*8 +: 8], rb[n*8 +: 8], hold[n*8 +: 8]);
         logic [7:0] eoa = {8{!ebn}};
         logic [7:0] eob = {8{eab}};
         chk("R5 R6 R7 R8 R10 R1 lane buses",
             {32'd0, a_bus[n*8 +: 8], b_bus[n*8 +: 8], a_out[n*8 +: 8], b_out[n*8 +: 8]},
             {32'd0, ea, eb, ea & eoa, eb & eob});
         chk("R5 R6 lane enables", {48'd0, a_oe[n*8 +: 8], b_oe[n*8 +: 8]},
             {48'd0, eoa, eob});
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [15:0] ra, rb;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R11: registers clear after reset
      read_regs("R11 reset", 16'h0000, 16'h0000);

      // R2: load both registers from isolated buses
      en_ab = 2'b00; en_ba_n = 2'b11; sel_ab = 2'b00; sel_ba = 2'b00;
      a_in = 16'h3C96; b_in = 16'hE14B;
      @(negedge clk);
      strobe(2'b11, 2'b11);
      ra = 16'h3C96; rb = 16'hE14B;
      read_regs("R2 load", ra, rb);

      // R2 latency: B register changes on the third edge after the strobe rises
      en_ab = 2'b00; en_ba_n = 2'b11; sel_ab = 2'b00; sel_ba = 2'b00;
      b_in = 16'h4D2E;
      @(negedge clk);
      cap_ba = 2'b11;
      en_ba_n = 2'b00; sel_ba = 2'b11;
      repeat (2) @(negedge clk);
      #1 chk("R2 not yet loaded", 64'(a_bus), 64'(rb));
      @(negedge clk);
      #1 chk("R2 loaded on third edge", 64'(a_bus), 64'h4D2E);
      cap_ba = 2'b00;
      repeat (4) @(negedge clk);
      rb = 16'h4D2E;

      // R5 R6 R7 R8 R10 R1: sweep every control combination, lanes differ
      for (int c = 0; c < 16; c++) begin
         logic [3:0]  c1 = 4'((c * 7 + 3) & 15);
         logic [15:0] p  = {8'(c * 17 + 1), 8'(c * 29 + 5)};
         logic [15:0] q  = {8'(c * 13 + 7), 8'(c * 37 + 2)};
         logic [15:0] r  = {8'(c * 11 + 9), 8'(c * 41 + 4)};
         en_ab = 2'b00; en_ba_n = 2'b11; sel_ab = 2'b00; sel_ba = 2'b00;
         a_in = p; b_in = ~p;
         @(negedge clk);
         {en_ab[0], en_ba_n[0], sel_ab[0], sel_ba[0]} = 4'(c);
         {en_ab[1], en_ba_n[1], sel_ab[1], sel_ba[1]} = c1;
         a_in = q; b_in = r;
         #1 check_lanes(ra, rb, p);
         @(negedge clk);
         a_in = ~q; b_in = ~r;
         #1 check_lanes(ra, rb, p);
      end

      // R3: held strobe captures once
      en_ab = 2'b00; en_ba_n = 2'b11; sel_ab = 2'b00; sel_ba = 2'b00;
      a_in = 16'h1111;
      @(negedge clk);
      cap_ab = 2'b01;
      repeat (4) @(negedge clk);
      a_in = 16'h2222;
      repeat (4) @(negedge clk);
      cap_ab = 2'b00;
      repeat (4) @(negedge clk);
      ra = {ra[15:8], 8'h11};
      read_regs("R3 R1 held strobe", ra, rb);

      // R1: strobe on lane 1 only
      en_ab = 2'b00; en_ba_n = 2'b11; sel_ab = 2'b00; sel_ba = 2'b00;
      a_in = 16'h6699;
      @(negedge clk);
      strobe(2'b10, 2'b00);
      ra = {8'h66, ra[7:0]};
      read_regs("R1 lane 1 only", ra, rb);

      // R4: capture while B is driven from the stored register
      en_ab = 2'b11; sel_ab = 2'b11; en_ba_n = 2'b11; sel_ba = 2'b00;
      a_in = 16'h5AC3;
      @(negedge clk);
      strobe(2'b11, 2'b00);
      ra = 16'h5AC3;
      #1 chk("R4 capture under stored drive", 64'(b_out), 64'(ra));

      // R4: capture the value the block drives on bus A
      en_ab = 2'b00; sel_ab = 2'b00; en_ba_n = 2'b00; sel_ba = 2'b11;
      a_in = 16'hFFFF;
      @(negedge clk);
      strobe(2'b11, 2'b00);
      ra = rb;
      read_regs("R4 self capture", ra, rb);

      // R9: store A data in both registers
      en_ab = 2'b11; sel_ab = 2'b00; en_ba_n = 2'b11; sel_ba = 2'b00;
      a_in = 16'h7E81; b_in = 16'h0000;
      @(negedge clk);
      strobe(2'b00, 2'b11);
      rb = 16'h7E81;
      read_regs("R9 A into B", ra, rb);

      // R9 mirror: store B data in both registers
      en_ab = 2'b00; sel_ab = 2'b00; en_ba_n = 2'b00; sel_ba = 2'b00;
      b_in = 16'h0FF0; a_in = 16'hAAAA;
      @(negedge clk);
      strobe(2'b11, 2'b00);
      ra = 16'h0FF0;
      read_regs("R9 B into A", ra, rb);

      // R11: reset in mutual-drive mode clears the holding register
      en_ab = 2'b11; en_ba_n = 2'b00; sel_ab = 2'b00; sel_ba = 2'b00;
      a_in = 16'hFFFF; b_in = 16'hFFFF;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1 chk("R11 hold cleared", {32'd0, a_bus, b_bus}, 64'd0);
      @(negedge clk);
      read_regs("R11 regs cleared", 16'h0000, 16'h0000);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule